// File: doc/BRIEF.md
# Flash Cycle Sequencer Control and Status Register

This block is the software-facing register for a hardware flash-cycle sequencer. Software starts a cycle with a single register write. That write carries a cycle kind, a byte count stored as the number of bytes minus one, and a go bit. The block turns an accepted go into a one-cycle start pulse for the cycle engine. It holds a busy flag while the cycle runs. At the end of the cycle it records a sticky done flag, plus a sticky error flag if the engine reported a fault. Software clears each sticky flag by writing a one to its bit.

A read-only bit reflects an external descriptor-valid input. A start request is accepted only when that bit is set and no cycle is running. A request refused for either reason is dropped, and the error flag is raised instead. A 64-byte data window of sixteen 32-bit words sits in the same address space and holds the data bytes exchanged with flash. The cycle engine is a stand-in. It ends each cycle after a programmable number of clocks and can be told to report a fault.

Top module: `fseq_csr`

Word addresses: 0 is the control/status word, 1 is the engine configuration word, and 16 to 31 are the data window.

Control/status bit positions:

| Bits | Field | Access |
|---|---|---|
| 0 | go | write; always reads 0 |
| 3:1 | cycle kind | captured on an accepted go |
| 9:4 | byte count minus one | captured on an accepted go |
| 16 | busy | read-only |
| 17 | done | write one to clear |
| 18 | error | write one to clear |
| 19 | descriptor valid | read-only |

Cycle kind codes: 0 read, 1 write, 2 small-block erase, 3 large-block erase, 4 parameter-table read, 5 identification read, 6 status write, 7 status read.

Configuration word: bits 7:0 hold the engine delay D, and bit 8 holds the fault-inject flag.

## Requirements
- R1: After reset, every mapped word reads zero, except bit 19 of address 0, which follows the descriptor-valid input.
- R2: An accepted go captures the kind (bits 3:1) and the count-minus-one (bits 9:4). Address 0 reads these back. cyc_kind_o shows the kind, and cyc_len_o shows the count field plus one (1 to 64).
- R3: An accepted go write produces exactly one cyc_go_o pulse in the cycle after the write. Bit 0 always reads zero.
- R4: Busy (bit 16) rises together with the go pulse. It stays high for D+2 cycles, where D is the configured delay, then falls.
- R5: Done (bit 17) is set when the cycle ends. It stays set through later go requests and through writes with bit 17 at zero, and clears only when a one is written to bit 17.
- R6: Error (bit 18) is set when a cycle ends while fault-inject was set at the go. It clears only when a one is written to bit 18.
- R7: A go request while busy is ignored: no pulse and no change to kind or count. It sets the error flag.
- R8: A go request while descriptor-valid is low is ignored in the same way and sets the error flag. Bit 19 reads the descriptor-valid input.
- R9: When a cycle ends in the same clock as a write-one-to-clear of done, the flag ends up set.
- R10: Addresses 16 to 31 read back the last word written to them. Unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| desc_valid_i | input | 1 | Descriptor-valid indication, read-only at bit 19 |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| cyc_go_o | output | 1 | One-cycle start pulse to the cycle engine |
| cyc_kind_o | output | 3 | Captured cycle kind |
| cyc_len_o | output | 7 | Captured byte count (1 to 64) |

## Verification
The main function is exercised in three ways:
- Cycles of different kinds with counts at both ends of the range (64 bytes and a few bytes). These show that the minus-one coding and the field positions are captured correctly.
- Cycles with delays of 0, 2, 3 and 10, with and without fault injection. These separate correct busy timing from off-by-one engine latency, and show the error flag tracking only injected faults.
- Refused starts, both during a running cycle and with the descriptor invalid, which must leave the captured fields untouched. A clear write timed to land on the very clock a cycle ends, which pins down the set-over-clear priority.

A behavioural model checks every field on every clock.

// File: rtl/fseq_pkg.sv
package fseq_pkg;
  typedef enum logic [2:0] {
    KIND_READ        = 3'd0,
    KIND_WRITE       = 3'd1,
    KIND_ERASE_SMALL = 3'd2,
    KIND_ERASE_LARGE = 3'd3,
    KIND_READ_PARAM  = 3'd4,
    KIND_READ_IDENT  = 3'd5,
    KIND_WRITE_STAT  = 3'd6,
    KIND_READ_STAT   = 3'd7
  } cyc_kind_e;

  localparam int KIND_W    = 3;
  localparam int GO_BIT    = 0;
  localparam int KIND_LSB  = 1;
  localparam int LEN_LSB   = 4;
  localparam int BUSY_BIT  = 16;
  localparam int DONE_BIT  = 17;
  localparam int FAIL_BIT  = 18;
  localparam int DV_BIT    = 19;
  localparam int INJ_BIT   = 8;
  localparam int CTL_ADDR  = 0;
  localparam int CFG_ADDR  = 1;
endpackage

// File: rtl/fseq_ctrl.sv
module fseq_ctrl
  import fseq_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             desc_valid_i,
  input  logic             ctl_we_i,
  input  logic             go_bit_i,
  input  cyc_kind_e        kind_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             clr_done_i,
  input  logic             clr_fail_i,
  input  logic             fin_i,
  input  logic             fin_err_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             fail_o,
  output logic             go_o,
  output cyc_kind_e        kind_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic busy_q, done_q, fail_q, go_q;
  logic busy_d, done_d, fail_d;
  logic req, accept, refuse;
  cyc_kind_e kind_q;
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    req    = ctl_we_i & go_bit_i;
    accept = req & ~busy_q & desc_valid_i;
    refuse = req & ~accept;
    busy_d = accept ? 1'b1 : (fin_i ? 1'b0 : busy_q);
    // completion sets win over a same-cycle clear
    done_d = (done_q & ~(ctl_we_i & clr_done_i)) | fin_i;
    fail_d = (fail_q & ~(ctl_we_i & clr_fail_i)) | refuse | fin_err_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      fail_q <= 1'b0;
      go_q   <= 1'b0;
      kind_q <= KIND_READ;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      fail_q <= fail_d;
      go_q   <= accept;
      if (accept) begin
        kind_q <= kind_i;
        cnt_q  <= cnt_i;
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign fail_o = fail_q;
  assign go_o   = go_q;
  assign kind_o = kind_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/fseq_engine_stub.sv
module fseq_engine_stub #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we_i,
  input  logic [DLY_W-1:0] dly_i,
  input  logic             inj_i,
  input  logic             go_i,
  output logic [DLY_W-1:0] dly_o,
  output logic             inj_o,
  output logic             fin_o,
  output logic             fin_err_o
);
  logic [DLY_W-1:0] dly_q, cnt_q, cnt_d;
  logic inj_cfg_q, run_q, run_d, inj_q;
  logic at_end;

  always_comb begin
    at_end = run_q & (cnt_q == '0);
    run_d  = run_q;
    cnt_d  = cnt_q;
    if (go_i) begin
      run_d = 1'b1;
      cnt_d = dly_q;
    end else if (run_q) begin
      if (at_end) run_d = 1'b0;
      else        cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly_q     <= '0;
      inj_cfg_q <= 1'b0;
      run_q     <= 1'b0;
      cnt_q     <= '0;
      inj_q     <= 1'b0;
    end else begin
      if (cfg_we_i) begin
        dly_q     <= dly_i;
        inj_cfg_q <= inj_i;
      end
      run_q <= run_d;
      cnt_q <= cnt_d;
      if (go_i) inj_q <= inj_cfg_q;
    end
  end

  assign dly_o     = dly_q;
  assign inj_o     = inj_cfg_q;
  assign fin_o     = at_end;
  assign fin_err_o = at_end & inj_q;
endmodule

// File: rtl/fseq_data_win.sv
module fseq_data_win #(
  parameter int WORDS = 16,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o
);
  logic [WORDS-1:0][31:0] words;

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic [31:0] word_q;
    logic        word_en;
    assign word_en = we_i & (idx_i == IDX_W'(w));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       word_q <= '0;
      else if (word_en) word_q <= wdata_i;
    end
    assign words[w] = word_q;
  end

  assign rdata_o = words[idx_i];
endmodule

// File: rtl/fseq_csr.sv
module fseq_csr
  import fseq_pkg::*;
#(
  parameter int DATA_BYTES = 64,
  parameter int DLY_W      = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            desc_valid_i,
  input  logic                            reg_we_i,
  input  logic [$clog2(DATA_BYTES/4):0]   reg_addr_i,
  input  logic [31:0]                     reg_wdata_i,
  output logic [31:0]                     reg_rdata_o,
  output logic                            cyc_go_o,
  output logic [2:0]                      cyc_kind_o,
  output logic [$clog2(DATA_BYTES):0]     cyc_len_o
);
  localparam int WIN_WORDS = DATA_BYTES / 4;
  localparam int IDX_W     = $clog2(WIN_WORDS);
  localparam int ADDR_W    = IDX_W + 1;
  localparam int CNT_W     = $clog2(DATA_BYTES);

  logic ctl_we, cfg_we, win_hit, win_we;
  logic st_busy, st_done, st_fail, go_pulse, fin, fin_err, inj_cfg;
  cyc_kind_e kind_q;
  logic [CNT_W-1:0] cnt_q;
  logic [DLY_W-1:0] dly_cfg;
  logic [31:0] win_rdata, ctl_word, cfg_word;

  assign ctl_we  = reg_we_i & (reg_addr_i == ADDR_W'(CTL_ADDR));
  assign cfg_we  = reg_we_i & (reg_addr_i == ADDR_W'(CFG_ADDR));
  assign win_hit = reg_addr_i[ADDR_W-1];
  assign win_we  = reg_we_i & win_hit;

  fseq_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .desc_valid_i (desc_valid_i),
    .ctl_we_i     (ctl_we),
    .go_bit_i     (reg_wdata_i[GO_BIT]),
    .kind_i       (cyc_kind_e'(reg_wdata_i[KIND_LSB +: KIND_W])),
    .cnt_i        (reg_wdata_i[LEN_LSB +: CNT_W]),
    .clr_done_i   (reg_wdata_i[DONE_BIT]),
    .clr_fail_i   (reg_wdata_i[FAIL_BIT]),
    .fin_i        (fin),
    .fin_err_i    (fin_err),
    .busy_o       (st_busy),
    .done_o       (st_done),
    .fail_o       (st_fail),
    .go_o         (go_pulse),
    .kind_o       (kind_q),
    .cnt_o        (cnt_q)
  );

  fseq_engine_stub #(.DLY_W(DLY_W)) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we_i  (cfg_we),
    .dly_i     (reg_wdata_i[DLY_W-1:0]),
    .inj_i     (reg_wdata_i[INJ_BIT]),
    .go_i      (go_pulse),
    .dly_o     (dly_cfg),
    .inj_o     (inj_cfg),
    .fin_o     (fin),
    .fin_err_o (fin_err)
  );

  fseq_data_win #(.WORDS(WIN_WORDS)) u_win (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (win_we),
    .idx_i   (reg_addr_i[IDX_W-1:0]),
    .wdata_i (reg_wdata_i),
    .rdata_o (win_rdata)
  );

  always_comb begin
    ctl_word = '0;
    ctl_word[KIND_LSB +: KIND_W] = kind_q;
    ctl_word[LEN_LSB +: CNT_W]   = cnt_q;
    ctl_word[BUSY_BIT]           = st_busy;
    ctl_word[DONE_BIT]           = st_done;
    ctl_word[FAIL_BIT]           = st_fail;
    ctl_word[DV_BIT]             = desc_valid_i;
    cfg_word = '0;
    cfg_word[DLY_W-1:0]          = dly_cfg;
    cfg_word[INJ_BIT]            = inj_cfg;
    if (win_hit)                                reg_rdata_o = win_rdata;
    else if (reg_addr_i == ADDR_W'(CTL_ADDR))   reg_rdata_o = ctl_word;
    else if (reg_addr_i == ADDR_W'(CFG_ADDR))   reg_rdata_o = cfg_word;
    else                                        reg_rdata_o = '0;
  end

  assign cyc_go_o   = go_pulse;
  assign cyc_kind_o = kind_q;
  assign cyc_len_o  = {1'b0, cnt_q} + 1'b1;
endmodule

// File: rtl/fseq_csr_chk.sv
module fseq_csr_chk
  import fseq_pkg::*;
#(
  parameter int DATA_BYTES = 64,
  localparam int ADDR_W = $clog2(DATA_BYTES/4) + 1,
  localparam int LEN_W  = $clog2(DATA_BYTES) + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              desc_valid_i,
  input logic              reg_we_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [31:0]       reg_wdata_i,
  input logic              cyc_go_o,
  input logic [LEN_W-1:0]  cyc_len_o,
  input logic              st_busy,
  input logic              st_done,
  input logic              st_fail
);
  p_len_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_go_o |-> (cyc_len_o != '0) && (int'(cyc_len_o) <= DATA_BYTES));

  p_go_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_go_o |=> !cyc_go_o);

  p_go_with_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_go_o |-> st_busy);

  p_busy_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_busy) |-> cyc_go_o);

  p_done_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(st_done) |-> $past(reg_we_i && reg_addr_i == ADDR_W'(CTL_ADDR) && reg_wdata_i[DONE_BIT]));

  p_fail_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(st_fail) |-> $past(reg_we_i && reg_addr_i == ADDR_W'(CTL_ADDR) && reg_wdata_i[FAIL_BIT]));

  p_go_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_go_o |-> !$past(st_busy));

  p_busy_refuse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we_i && reg_addr_i == ADDR_W'(CTL_ADDR) && reg_wdata_i[GO_BIT] && st_busy) |=> st_fail);

  p_go_needs_dv_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_go_o |-> $past(desc_valid_i));
endmodule

bind fseq_csr fseq_csr_chk #(.DATA_BYTES(DATA_BYTES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .desc_valid_i (desc_valid_i),
  .reg_we_i     (reg_we_i),
  .reg_addr_i   (reg_addr_i),
  .reg_wdata_i  (reg_wdata_i),
  .cyc_go_o     (cyc_go_o),
  .cyc_len_o    (cyc_len_o),
  .st_busy      (st_busy),
  .st_done      (st_done),
  .st_fail      (st_fail)
);

// File: tb/fseq_csr_tb_top.sv
module fseq_csr_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, dv, we;
  logic [4:0] addr;
  logic [31:0] wdata;
  wire  [31:0] rdata;
  wire  go;
  wire  [2:0] kind;
  wire  [6:0] len;

  fseq_csr dut_i (
    .clk(clk), .rst_n(rst_n), .desc_valid_i(dv), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .cyc_go_o(go), .cyc_kind_o(kind), .cyc_len_o(len)
  );

  int checks = 0, fails = 0;
  bit m_busy, m_done, m_err, m_go, m_inj, m_inj_l;
  int m_left, m_kind, m_cnt, m_dly;
  int unsigned m_win [16];

  function automatic logic [31:0] m_read(input logic [4:0] a);
    logic [31:0] r;
    r = '0;
    if (a[4]) r = m_win[a[3:0]];
    else if (a == 5'd0) begin
      r[3:1] = 3'(m_kind); r[9:4] = 6'(m_cnt);
      r[16] = m_busy; r[17] = m_done; r[18] = m_err; r[19] = dv;
    end else if (a == 5'd1) begin
      r[7:0] = 8'(m_dly); r[8] = m_inj;
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference model, stepped on every rising edge, compared 5 ns later
  always @(posedge clk) begin
    bit req, acc, rej, fin, ctl;
    logic [31:0] e;
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_err = 0; m_go = 0; m_inj = 0; m_inj_l = 0;
      m_left = 0; m_kind = 0; m_cnt = 0; m_dly = 0;
      foreach (m_win[i]) m_win[i] = 0;
    end else begin
      ctl = we && addr == 5'd0;
      req = ctl && wdata[0];
      acc = req && !m_busy && dv;
      rej = req && !acc;
      fin = m_busy && m_left == 1;
      m_err  = (m_err && !(ctl && wdata[18])) || rej || (fin && m_inj_l);
      m_done = (m_done && !(ctl && wdata[17])) || fin;
      if (m_busy && !fin) m_left--;
      if (fin) m_busy = 0;
      m_go = acc;
      if (acc) begin
        m_busy = 1; m_left = m_dly + 2; m_inj_l = m_inj;
        m_kind = int'(wdata[3:1]); m_cnt = int'(wdata[9:4]);
      end
      if (we && addr == 5'd1) begin m_dly = int'(wdata[7:0]); m_inj = wdata[8]; end
      if (we && addr[4]) m_win[addr[3:0]] = wdata;
    end
    #5;
    if (rst_n) begin
      chk("R3 go pulse", {31'b0, go}, {31'b0, m_go});
      chk("R2 kind port", {29'b0, kind}, 32'(m_kind));
      chk("R2 length port", {25'b0, len}, 32'(m_cnt + 1));
      e = m_read(addr);
      if (addr == 5'd0) begin
        chk("R3 go bit reads zero", {31'b0, rdata[0]}, 32'd0);
        chk("R2 kind/count fields", {22'b0, rdata[9:1]}, {22'b0, e[9:1]});
        chk("R4 busy", {31'b0, rdata[16]}, {31'b0, e[16]});
        chk("R5 R9 done", {31'b0, rdata[17]}, {31'b0, e[17]});
        chk("R6 error", {31'b0, rdata[18]}, {31'b0, e[18]});
        chk("R8 desc valid", {31'b0, rdata[19]}, {31'b0, e[19]});
      end else begin
        chk("R10 word read", rdata, e);
      end
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0; wdata = '0;
  endtask

  task automatic peek(input logic [4:0] a, output logic [31:0] v);
    @(negedge clk); addr = a; #1 v = rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int n = 0; n < 400; n++) begin
      peek(5'd0, v);
      if (!v[16]) break;
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; dv = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    peek(5'd0, v);  chk("R1 reset control word", v, 32'd0);
    peek(5'd1, v);  chk("R1 reset config word", v, 32'd0);
    peek(5'd20, v); chk("R1 reset window word", v, 32'd0);

    // R8: go with descriptor invalid
    wr(5'd0, 32'h1 | (32'd2 << 1) | (32'd5 << 4));
    peek(5'd0, v);
    chk("R8 refused go sets error", {31'b0, v[18]}, 32'd1);
    chk("R8 refused go leaves fields", {22'b0, v[9:1]}, 32'd0);
    wr(5'd0, 32'h1 << 18);
    peek(5'd0, v); chk("R6 error cleared by one", {31'b0, v[18]}, 32'd0);
    dv = 1'b1;

    // 64-byte read, delay 3
    wr(5'd1, 32'd3);
    wr(5'd0, 32'h1 | (32'd0 << 1) | (32'd63 << 4));
    chk("R3 pulse after accepted go", {31'b0, go}, 32'd1);
    chk("R2 length 64", {25'b0, len}, 32'd64);
    wait_idle();
    peek(5'd0, v);
    chk("R5 done after cycle", {31'b0, v[17]}, 32'd1);
    chk("R6 no error without inject", {31'b0, v[18]}, 32'd0);
    wr(5'd0, 32'h0);
    peek(5'd0, v); chk("R5 zero write keeps done", {31'b0, v[17]}, 32'd1);

    // injected fault, delay 0, identification read of 3 bytes
    wr(5'd1, 32'h1 << 8);
    wr(5'd0, 32'h1 | (32'd5 << 1) | (32'd2 << 4));
    chk("R2 length 3", {25'b0, len}, 32'd3);
    wait_idle();
    peek(5'd0, v); chk("R6 injected fault sets error", {31'b0, v[18]}, 32'd1);
    wr(5'd0, 32'h1 << 17);
    peek(5'd0, v);
    chk("R5 done cleared", {31'b0, v[17]}, 32'd0);
    chk("R6 error survives done clear", {31'b0, v[18]}, 32'd1);
    wr(5'd0, 32'h1 << 18);

    // R7: second go while busy
    wr(5'd1, 32'd10);
    wr(5'd0, 32'h1 | (32'd4 << 1) | (32'd7 << 4));
    wr(5'd0, 32'h1 | (32'd7 << 1) | (32'd1 << 4));
    peek(5'd0, v);
    chk("R7 busy refusal sets error", {31'b0, v[18]}, 32'd1);
    chk("R7 kind unchanged", {29'b0, v[3:1]}, 32'd4);
    chk("R7 count unchanged", {26'b0, v[9:4]}, 32'd7);
    wait_idle();
    wr(5'd0, 32'h3 << 17);

    // R9: clear lands on the finishing edge (delay 2 -> edge 4 after go)
    wr(5'd1, 32'd2);
    wr(5'd0, 32'h1 | (32'd1 << 1));
    repeat (2) @(negedge clk);
    @(negedge clk); we = 1'b1; addr = 5'd0; wdata = 32'h1 << 17;
    @(negedge clk); we = 1'b0; wdata = '0;
    #1 chk("R9 set wins over clear", {31'b0, rdata[17]}, 32'd1);
    wr(5'd0, 32'h1 << 17);

    // R5: a new go leaves done set
    wr(5'd1, 32'd0);
    wr(5'd0, 32'h1);
    wait_idle();
    wr(5'd0, 32'h1 | (32'd6 << 1));
    peek(5'd0, v); chk("R5 new go keeps done", {31'b0, v[17]}, 32'd1);
    wait_idle();

    // R10: data window
    for (int i = 0; i < 16; i++) wr(5'(16 + i), 32'hA5000000 ^ (32'(i) * 32'h01010101));
    for (int i = 0; i < 16; i++) begin
      peek(5'(16 + i), v);
      chk("R10 window readback", v, 32'hA5000000 ^ (32'(i) * 32'h01010101));
    end
    peek(5'd2, v); chk("R10 unmapped reads zero", v, 32'd0);
    peek(5'd15, v); chk("R10 unmapped reads zero", v, 32'd0);

    repeat (2) @(negedge clk);
    summary();
  end
endmodule